// File: doc/BRIEF.md
# Three-Channel Match Timer with Count Snapshot

This peripheral holds three independent 32-bit up-counters behind a small register port. Every counter owns three compare values, a reload value and a reload selector that names which of its own comparators (if any) sends the counter back to the reload value instead of letting it step past. A shared run register starts and stops each counter, and each equality between a running counter and one of its compare values raises a sticky flag that software clears by writing ones.

Because a live counter can change under a multi-cycle software read, each timer also owns a snapshot slot. Software writes a request to the slot, waits for its busy flag to drop, and then reads the same slot to get a frozen copy of the count. The register port accepts one access per cycle and never stalls, so it carries no ready signal: a write lands at the clock edge it is presented on, and read data is a combinational view of the register state.

Top module: `tri_match_timer`

## Requirements
- R1: After reset every register, counter, snapshot, busy bit and match flag reads 0, all counters are stopped, and `match_flag_o` and `irq_o` are 0.
- R2: The run register at word 0x1C holds one bit per timer in bits [2:0]; bit t set lets timer t advance, and a stopped counter keeps its value.
- R3: A running counter with reload selector 0 adds 1 every clock and rolls from 0xFFFFFFFF to 0.
- R4: Compare value n of timer t sits at word 3*t+n (words 0 to 8), the reload value of timer t at word 0x14+t, and the reload selector of timer t at word 0x18+t bits [1:0]; each reads back what was written.
- R5: A reload selector value s in 1..3 makes timer t load its reload value, instead of adding 1, on the clock where it is running and equal to compare value s-1 of its own set.
- R6: Writing word 0x10+t loads timer t with the written value at that edge, ahead of any step or reload; reading word 0x10+t returns the live count.
- R7: Writing word 0x24+t with bit 0 set requests a snapshot of timer t; a write with bit 0 clear does nothing. Bit t of word 0x28 reads 1 during the two cycles after the request edge. The slot then holds the count present in the cycle after the request edge; until then it reads the previous snapshot.
- R8: Bit 3*t+n of word 0x2C is set when timer t is running and equals its compare value n, stays set, and is cleared by writing 1 to it.
- R9: `match_flag_o` mirrors the flag word and `irq_o[t]` is the OR of timer t's three flags.
- R10: Reads of words outside the map return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| match_flag_o | output | 9 | Sticky compare flags, bit 3*t+n |
| irq_o | output | 3 | Per-timer OR of its compare flags |

## Verification
Register writes, counter loads and run changes take effect at the edge they are presented on, so a count reads back in the next cycle and a counter advances once per edge after its run bit is set, including the edge that clears it. A compare flag appears one edge after the matching count, and a snapshot is busy for exactly the two cycles after its request edge, holding the count from the first of them. The bench drives every access at the falling edge, consumes exactly one rising edge per access, and compares read data a nanosecond after the falling edge, so each expected value is computed from a known edge count.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int unsigned TMR_N   = 3;
  localparam int unsigned CMP_N   = 3;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned FLAG_N  = TMR_N * CMP_N;
  localparam int unsigned SEL_W   = $clog2(CMP_N + 1);

  // word addresses
  localparam int A_CMP     = 0;
  localparam int A_COUNT   = 16;
  localparam int A_RELOAD  = 20;
  localparam int A_SEL     = 24;
  localparam int A_RUN     = 28;
  localparam int A_SNAP    = 36;
  localparam int A_BUSY    = 40;
  localparam int A_FLAG    = 44;

  function automatic int flag_idx(input int t, input int n);
    return t * int'(CMP_N) + n;
  endfunction
endpackage

// File: rtl/tmt_counter.sv
module tmt_counter #(
  parameter int unsigned CW = 32,
  parameter int unsigned NC = 3,
  parameter int unsigned SW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   load,
  input  logic [CW-1:0]          load_val,
  input  logic [SW-1:0]          sel,
  input  logic [NC-1:0][CW-1:0]  cmp,
  input  logic [CW-1:0]          reload_val,
  output logic [CW-1:0]          cnt,
  output logic [NC-1:0]          hit
);
  logic reload_fire;

  for (genvar n = 0; n < NC; n++) begin : g_cmp
    assign hit[n] = run && (cnt == cmp[n]);
  end

  always_comb begin
    reload_fire = 1'b0;
    for (int n = 0; n < int'(NC); n++) begin
      if ((32'(sel) == 32'(n + 1)) && hit[n]) reload_fire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (run) begin
      if (reload_fire)     cnt <= reload_val;
      else                 cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tmt_snapshot.sv
module tmt_snapshot #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] live,
  output logic          busy,
  output logic [CW-1:0] held
);
  logic          phase;
  logic [CW-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      stage <= '0;
      held  <= '0;
    end else if (!busy) begin
      if (req) begin
        busy  <= 1'b1;
        phase <= 1'b0;
      end
    end else if (!phase) begin
      stage <= live;
      phase <= 1'b1;
    end else begin
      held  <= stage;
      busy  <= 1'b0;
      phase <= 1'b0;
    end
  end
endmodule

// File: rtl/tmt_flags.sv
module tmt_flags #(
  parameter int unsigned NT = 3,
  parameter int unsigned NC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT*NC-1:0] hit,
  input  logic [NT*NC-1:0] clr,
  output logic [NT*NC-1:0] flags,
  output logic [NT-1:0]    irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | hit;
  end

  for (genvar t = 0; t < NT; t++) begin : g_irq
    assign irq[t] = |flags[t*NC +: NC];
  end
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
  import tmt_pkg::*;
#(
  parameter int unsigned NT = TMR_N,
  parameter int unsigned NC = CMP_N,
  parameter int unsigned CW = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [CW-1:0]    reg_wdata,
  output logic [CW-1:0]    reg_rdata,
  output logic [NT*NC-1:0] match_flag_o,
  output logic [NT-1:0]    irq_o
);
  localparam int unsigned NF = NT * NC;
  localparam int unsigned SW = $clog2(NC + 1);

  logic [NF-1:0][CW-1:0] cmp_q;
  logic [NT-1:0][CW-1:0] reload_q;
  logic [NT-1:0][SW-1:0] sel_q;
  logic [NT-1:0]         run_q;
  logic [NT-1:0][CW-1:0] cnt_q;
  logic [NT-1:0][CW-1:0] snap_q;
  logic [NT-1:0]         busy_q;
  logic [NT-1:0]         load_stb;
  logic [NT-1:0]         snap_stb;
  logic [NF-1:0]         hit_all;
  logic [NF-1:0]         clr_stb;
  logic [NF-1:0]         flag_q;
  logic [31:0]           addr_n;

  assign addr_n = 32'(reg_addr);

  // strobes decoded from the register port
  always_comb begin
    load_stb = '0;
    snap_stb = '0;
    for (int t = 0; t < int'(NT); t++) begin
      load_stb[t] = reg_wr_en && (addr_n == 32'(A_COUNT + t));
      snap_stb[t] = reg_wr_en && (addr_n == 32'(A_SNAP + t)) && reg_wdata[0];
    end
    clr_stb = (reg_wr_en && (addr_n == 32'(A_FLAG))) ? reg_wdata[NF-1:0] : '0;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      reload_q <= '0;
      sel_q    <= '0;
      run_q    <= '0;
    end else if (reg_wr_en) begin
      for (int i = 0; i < int'(NF); i++)
        if (addr_n == 32'(A_CMP + i)) cmp_q[i] <= reg_wdata;
      for (int t = 0; t < int'(NT); t++) begin
        if (addr_n == 32'(A_RELOAD + t)) reload_q[t] <= reg_wdata;
        if (addr_n == 32'(A_SEL + t))    sel_q[t]    <= reg_wdata[SW-1:0];
      end
      if (addr_n == 32'(A_RUN)) run_q <= reg_wdata[NT-1:0];
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    tmt_counter #(.CW(CW), .NC(NC), .SW(SW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q[t]),
      .load       (load_stb[t]),
      .load_val   (reg_wdata),
      .sel        (sel_q[t]),
      .cmp        (cmp_q[t*NC +: NC]),
      .reload_val (reload_q[t]),
      .cnt        (cnt_q[t]),
      .hit        (hit_all[t*NC +: NC])
    );

    tmt_snapshot #(.CW(CW)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (snap_stb[t]),
      .live  (cnt_q[t]),
      .busy  (busy_q[t]),
      .held  (snap_q[t])
    );
  end

  tmt_flags #(.NT(NT), .NC(NC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_all),
    .clr   (clr_stb),
    .flags (flag_q),
    .irq   (irq_o)
  );

  assign match_flag_o = flag_q;

  // read path
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < int'(NF); i++)
      if (addr_n == 32'(A_CMP + i)) reg_rdata = cmp_q[i];
    for (int t = 0; t < int'(NT); t++) begin
      if (addr_n == 32'(A_COUNT + t))  reg_rdata = cnt_q[t];
      if (addr_n == 32'(A_RELOAD + t)) reg_rdata = reload_q[t];
      if (addr_n == 32'(A_SEL + t))    reg_rdata = {{(CW-SW){1'b0}}, sel_q[t]};
      if (addr_n == 32'(A_SNAP + t))   reg_rdata = snap_q[t];
    end
    if (addr_n == 32'(A_RUN))  reg_rdata = {{(CW-NT){1'b0}}, run_q};
    if (addr_n == 32'(A_BUSY)) reg_rdata = {{(CW-NT){1'b0}}, busy_q};
    if (addr_n == 32'(A_FLAG)) reg_rdata = {{(CW-NF){1'b0}}, flag_q};
  end
endmodule

// File: rtl/tmt_checker.sv
module tmt_checker #(
  parameter int unsigned NT = 3,
  parameter int unsigned NC = 3,
  parameter int unsigned CW = 32,
  parameter int unsigned SW = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NT-1:0]          run_q,
  input logic [NT-1:0]          load_stb,
  input logic [NT-1:0][CW-1:0]  cnt_q,
  input logic [NT-1:0][SW-1:0]  sel_q,
  input logic [NT-1:0]          busy_q,
  input logic [NT-1:0][CW-1:0]  snap_q,
  input logic [NT*NC-1:0]       flag_q,
  input logic [NT*NC-1:0]       clr_stb
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    // R2: a stopped, unloaded counter keeps its value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[t] && !load_stb[t]) |=> $stable(cnt_q[t]));

    // R3: free-running counter steps by one, wrapping
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[t] && !load_stb[t] && sel_q[t] == '0) |=> (cnt_q[t] == $past(cnt_q[t]) + CW'(1)));

    // R7: busy lasts exactly two cycles
    p_busy_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q[t]) |=> busy_q[t] ##1 !busy_q[t]);

    // R7: snapshot slot only changes while busy
    p_snap_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q[t] |=> $stable(snap_q[t]));
  end

  for (genvar i = 0; i < NT*NC; i++) begin : g_f
    // R8: a flag stays set until cleared
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_stb[i]) |=> flag_q[i]);
  end
endmodule

bind tri_match_timer tmt_checker #(.NT(NT), .NC(NC), .CW(CW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .load_stb (load_stb),
  .cnt_q    (cnt_q),
  .sel_q    (sel_q),
  .busy_q   (busy_q),
  .snap_q   (snap_q),
  .flag_q   (flag_q),
  .clr_stb  (clr_stb)
);

// File: tb/sim_tri_match_timer.sv
module sim_tri_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  match_flag_o;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_port;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event  mon_ev;

  always #2 clk = ~clk;

  tri_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .match_flag_o(match_flag_o), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(mon_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb.pop_front();
        got = it.is_port ? {20'b0, irq_o, match_flag_o} : reg_rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr  = 6'(a);
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr  = 6'(a);
    reg_wr_en = 1'b0;
    it.is_port = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #1 -> mon_ev;
    @(negedge clk);
  endtask

  task automatic port_chk(input logic [2:0] irq_e, input logic [8:0] flag_e, input string tag);
    item_t it;
    it.is_port = 1'b1; it.exp = {20'b0, irq_e, flag_e}; it.tag = tag;
    sb.push_back(it);
    #1 -> mon_ev;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(16, 32'h0, "R1 count0 after reset");
    rd(28, 32'h0, "R1 run word after reset");
    rd(44, 32'h0, "R1 flag word after reset");
    rd(37, 32'h0, "R1 snapshot1 after reset");
    port_chk(3'b000, 9'h000, "R1 irq and flags after reset");

    // R4 map readback
    wr(4, 32'h1234_5678);
    rd(4, 32'h1234_5678, "R4 compare word 4");
    wr(21, 32'hCAFE_0001);
    rd(21, 32'hCAFE_0001, "R4 reload word timer1");
    wr(25, 32'h3);
    rd(25, 32'h3, "R4 selector timer1");
    wr(4, 32'h0); wr(25, 32'h0); wr(21, 32'h0);

    // R6 load while stopped
    wr(17, 32'h0BAD_F00D);
    rd(17, 32'h0BAD_F00D, "R6 count1 load");

    // R5 wrap via compare 0 reload (timer0)
    wr(0, 32'hFFFF_FFFF);
    wr(20, 32'h0);
    wr(24, 32'h1);
    wr(16, 32'hFFFF_FFFD);
    wr(28, 32'h1);
    idle(2);
    wr(28, 32'h0);
    rd(16, 32'h0, "R5 count0 after three steps across all-ones");
    port_chk(3'b001, 9'h001, "R8 R9 flag for compare 0 of timer0");

    // R3 free-run ignores reload value
    wr(20, 32'h5);
    wr(24, 32'h0);
    wr(16, 32'hFFFF_FFFF);
    wr(28, 32'h1);
    wr(28, 32'h0);
    rd(16, 32'h0, "R3 count0 rolls to zero with selector 0");
    // R5 reload picks reload value
    wr(24, 32'h1);
    wr(16, 32'hFFFF_FFFF);
    wr(28, 32'h1);
    wr(28, 32'h0);
    rd(16, 32'h5, "R5 count0 reloads with selector 1");

    // R8 clear
    wr(44, 32'h1FF);
    rd(44, 32'h0, "R8 flags cleared by writing ones");

    // R5 reload by compare 1 of timer2
    wr(6, 32'd100); wr(7, 32'd5); wr(8, 32'd100);
    wr(22, 32'd2);
    wr(26, 32'd2);
    wr(18, 32'd0);
    wr(28, 32'h4);
    idle(7);
    wr(28, 32'h0);
    rd(18, 32'd4, "R5 count2 after eight steps with reload at 5");
    port_chk(3'b100, 9'h080, "R9 irq2 from compare 1 of timer2");
    // R2 stopped counter holds
    idle(3);
    rd(18, 32'd4, "R2 count2 holds while stopped");
    wr(44, 32'h080);
    rd(44, 32'h0, "R8 flag 7 cleared");

    // R7 snapshot of a stopped timer0
    wr(16, 32'hA5A5_0001);
    wr(36, 32'h0);
    rd(40, 32'h0, "R7 request with bit0 clear ignored");
    wr(36, 32'h1);
    rd(40, 32'h1, "R7 busy first cycle");
    rd(36, 32'h0, "R7 previous snapshot while busy");
    rd(40, 32'h0, "R7 busy dropped after two cycles");
    rd(36, 32'hA5A5_0001, "R7 snapshot of timer0");

    // R7 snapshot of a running timer1, R6 load priority
    wr(28, 32'h2);
    wr(17, 32'h0000_1000);
    wr(37, 32'h1);
    rd(40, 32'h2, "R7 busy bit of timer1");
    idle(2);
    rd(37, 32'h0000_1001, "R7 snapshot holds count one cycle after request");
    wr(28, 32'h0);

    // R10 unmapped
    rd(9, 32'h0, "R10 unmapped word 9");
    rd(48, 32'h0, "R10 unmapped word 48");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule